// File: doc/BRIEF.md
# SPI EEPROM status register controller

This block is the instruction and status-register logic of a serial EEPROM slave on an SPI bus (mode 0 or mode 3). It samples chip select, serial clock, serial data in and a write-protect pin in the system clock domain. It decodes four single-byte instructions: set write enable, clear write enable, read status, and write status. It holds the write-enable flag and the two protect-area bits. The protect-area bits go straight to the memory engine, which uses them to refuse writes to guarded addresses.

A status write is guarded. The write-enable flag must be set, no write may be running, the write-protect pin must stay high for the whole command, and chip select must rise exactly after the 16th bit. An accepted status write starts a self-timed cycle of `TW_CYCLES` system clocks. During that cycle the busy flag reads 1. When the cycle ends, the new protect bits take effect and the write-enable flag is cleared. The status can be read at any time, including during the cycle, and it shows these flags as they change.

Top module: `eesr_ctrl`

## Requirements
- R1: A read-status command (opcode 0x05) makes the block shift out the status byte MSB first, one bit after each falling serial-clock edge. The byte is repeated for as long as chip select stays low, and each bit is taken live. Status layout: bit 3 = protect bit 1, bit 2 = protect bit 0, bit 1 = write-enable flag, bit 0 = busy; bits 7..4 always read 0. The same behaviour holds with the clock idling high (mode 3).
- R2: Opcode 0x06 sets the write-enable flag and opcode 0x04 clears it, but only when chip select rises right after the 8th bit. A command of any other length leaves the flag unchanged.
- R3: A write-status command (opcode 0x01 followed by one data byte) is ignored when the write-enable flag is 0.
- R4: A write-status command is ignored unless chip select rises after exactly 16 bits.
- R5: A write-status command is ignored if the write-protect input is low at any moment while chip select is low. In that case the write-enable flag stays as it was.
- R6: While the busy flag is 1, write-status, write-enable and write-disable commands are all ignored.
- R7: An accepted write-status command sets the busy flag for `TW_CYCLES` system clocks. At the end of the cycle the busy flag and the write-enable flag both become 0.
- R8: The protect bits, and the `prot_area` output, take data bits 3:2 only when the write cycle ends. The other data bits have no effect. The protect code 00 means no area, 01 the upper quarter, 10 the upper half and 11 the whole array.
- R9: An opcode other than the four above is ignored until chip select rises.
- R10: After reset, the write-enable flag, the busy flag and the protect bits are 0. A command counts only after chip select has been seen high and then gone low.
- R11: `spi_miso_oe` is 1 only while status bits are being shifted out, and it returns to 0 once chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write-protect pin, active low |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| prot_area | output | 2 | Current protect-area code for the memory engine |

## Verification
A wrong flag inside the block shows up at the ports one status read later. A write-enable flag that is set when it should not be lets a later status write change `prot_area`. A busy flag that clears too early or too late shows up as a wrong bit 0 in a read taken during the cycle, or as `prot_area` changing a cycle count other than `TW_CYCLES` after chip select rises. Every test reads the status back through the serial interface right after the stimulus. A command that was rejected therefore shows as unchanged bits in the very next read, and again when `prot_area` is sampled after a full write-cycle time.

// File: rtl/eesr_pkg.sv
package eesr_pkg;
   typedef enum logic [7:0] {
      OP_WRSR = 8'h01,
      OP_WRDI = 8'h04,
      OP_RDSR = 8'h05,
      OP_WREN = 8'h06
   } eesr_op_e;

   // status byte: {0000, prot[1:0], wel, busy}
   function automatic logic [7:0] pack_status(input logic [1:0] prot,
                                              input logic wel,
                                              input logic busy);
      return {4'b0000, prot, wel, busy};
   endfunction
endpackage

// File: rtl/eesr_sync.sv
module eesr_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/eesr_frame.sv
module eesr_frame (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       mosi,
   output logic       sess,
   output logic       sck_fall,
   output logic       end_evt,
   output logic [2:0] bitpos,
   output logic [1:0] nbytes,
   output logic [7:0] opcode,
   output logic [1:0] data_prot
);
   logic       prev_cs;   // resets to 0: a fall needs cs seen high first
   logic       prev_sck;
   logic [7:0] shreg;
   logic       cs_fall, cs_rise, sck_rise;
   logic [7:0] shifted;

   assign cs_fall  = prev_cs & ~cs_n;
   assign cs_rise  = ~prev_cs & cs_n;
   assign sck_rise = ~prev_sck & sck & sess & ~cs_n;
   assign sck_fall = prev_sck & ~sck & sess & ~cs_n;
   assign end_evt  = cs_rise & sess;
   assign shifted  = {shreg[6:0], mosi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_cs   <= 1'b0;
         prev_sck  <= 1'b0;
         sess      <= 1'b0;
         bitpos    <= '0;
         nbytes    <= '0;
         shreg     <= '0;
         opcode    <= '0;
         data_prot <= '0;
      end else begin
         prev_cs  <= cs_n;
         prev_sck <= sck;
         if (cs_fall) begin
            sess   <= 1'b1;
            bitpos <= '0;
            nbytes <= '0;
         end else if (cs_rise) begin
            sess <= 1'b0;
         end else if (sck_rise) begin
            shreg  <= shifted;
            bitpos <= bitpos + 3'd1;
            if (bitpos == 3'd7) begin
               if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
               if (nbytes == 2'd0) opcode    <= shifted;
               if (nbytes == 2'd1) data_prot <= shifted[3:2];
            end
         end
      end
   end
endmodule

// File: rtl/eesr_wtimer.sv
module eesr_wtimer #(
   parameter int TW_CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(TW_CYCLES + 1);
   logic [CW-1:0] cnt;

   assign done = busy && (cnt == CW'(TW_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
         end
      end else if (done) begin
         busy <= 1'b0;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end
endmodule

// File: rtl/eesr_ctrl.sv
module eesr_ctrl #(
   parameter int TW_CYCLES   = 5000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_cs_n,
   input  logic       spi_sck,
   input  logic       spi_mosi,
   input  logic       wp_n,
   output logic       spi_miso,
   output logic       spi_miso_oe,
   output logic [1:0] prot_area
);
   import eesr_pkg::*;

   generate
      if (TW_CYCLES < 1) begin : g_bad_tw
         $error("TW_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
   endgenerate

   // synchronised pins {cs_n, sck, mosi, wp_n}
   logic [3:0] raw_in, syn_in;
   logic       s_cs_n, s_sck, s_mosi, s_wp_n;
   assign raw_in = {spi_cs_n, spi_sck, spi_mosi, wp_n};

   eesr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );
   assign {s_cs_n, s_sck, s_mosi, s_wp_n} = syn_in;

   logic       sess, sck_fall, end_evt;
   logic [2:0] bitpos;
   logic [1:0] nbytes;
   logic [7:0] opcode;
   logic [1:0] data_prot;

   eesr_frame u_frame (
      .clk(clk), .rst_n(rst_n), .cs_n(s_cs_n), .sck(s_sck), .mosi(s_mosi),
      .sess(sess), .sck_fall(sck_fall), .end_evt(end_evt), .bitpos(bitpos),
      .nbytes(nbytes), .opcode(opcode), .data_prot(data_prot)
   );

   logic busy, done, accept;
   eesr_wtimer #(.TW_CYCLES(TW_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .done(done)
   );

   logic       wel;
   logic [1:0] prot, pend;
   logic       wp_hit;
   logic [7:0] status;
   logic       end_one, end_two, rd_on;

   assign status  = pack_status(prot, wel, busy);
   assign end_one = end_evt && (nbytes == 2'd1) && (bitpos == 3'd0);
   assign end_two = end_evt && (nbytes == 2'd2) && (bitpos == 3'd0);
   assign accept  = end_two && (opcode == OP_WRSR) && wel && !busy
                    && !wp_hit && s_wp_n;
   assign rd_on   = sess && (opcode == OP_RDSR) && (nbytes != 2'd0);
   assign prot_area = prot;

   // write-protect watch over the whole command
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wp_hit <= 1'b0;
      else if (!sess)            wp_hit <= 1'b0;
      else if (!s_wp_n)          wp_hit <= 1'b1;
   end

   // write-enable flag and protect bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         prot <= '0;
         pend <= '0;
      end else begin
         if (done) begin
            prot <= pend;
            wel  <= 1'b0;
         end else if (end_one && !busy) begin
            if (opcode == OP_WREN) wel <= 1'b1;
            if (opcode == OP_WRDI) wel <= 1'b0;
         end
         if (accept) pend <= data_prot;
      end
   end

   // serial output, changes after falling sck
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spi_miso    <= 1'b0;
         spi_miso_oe <= 1'b0;
      end else if (!sess || end_evt) begin
         spi_miso    <= 1'b0;
         spi_miso_oe <= 1'b0;
      end else if (sck_fall && rd_on) begin
         spi_miso    <= status[3'd7 - bitpos];
         spi_miso_oe <= 1'b1;
      end
   end
endmodule

// File: rtl/eesr_ctrl_chk.sv
module eesr_ctrl_chk #(
   parameter int TW_CYCLES = 5000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       s_cs_n,
   input logic       sess,
   input logic       busy,
   input logic       wel,
   input logic [1:0] prot,
   input logic       spi_miso_oe
);
   int busy_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
      else           busy_len <= 0;
   end

   // R3
   wrsr_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel));

   // R7
   busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == TW_CYCLES));

   // R7
   wel_clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel);

   // R8
   prot_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot) |-> $fell(busy));

   // R10
   session_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sess) |-> $past(s_cs_n, 2));

   // R11
   oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_miso_oe |-> $past(!s_cs_n));
endmodule

bind eesr_ctrl eesr_ctrl_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .s_cs_n(s_cs_n), .sess(sess), .busy(busy),
   .wel(wel), .prot(prot), .spi_miso_oe(spi_miso_oe)
);

// File: tb/sim_eesr_ctrl.sv
module sim_eesr_ctrl;
   localparam int TW = 1500;
   localparam int HP = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
   logic miso, miso_oe;
   logic [1:0] prot_area;
   logic mode3 = 1'b0;
   int total = 0, bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   eesr_ctrl #(.TW_CYCLES(TW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
      .spi_mosi(mosi), .wp_n(wp_n), .spi_miso(miso),
      .spi_miso_oe(miso_oe), .prot_area(prot_area)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic spi_begin();
      sck = mode3;
      tick(HP);
      cs_n = 1'b0;
      tick(HP);
   endtask

   task automatic spi_bits(input logic [15:0] v, input int n, output logic [15:0] r);
      r = '0;
      for (int i = n - 1; i >= 0; i--) begin
         if (mode3) sck = 1'b0;
         mosi = v[i];
         tick(HP);
         r[i] = miso;
         sck = 1'b1;
         tick(HP);
         if (!mode3) sck = 1'b0;
      end
   endtask

   task automatic spi_end();
      tick(HP);
      cs_n = 1'b1;
      tick(2 * HP);
   endtask

   task automatic cmd(input logic [15:0] v, input int n);
      logic [15:0] r;
      spi_begin();
      spi_bits(v, n, r);
      spi_end();
   endtask

   task automatic read_status(input int nb, output logic [7:0] s0, output logic [7:0] s1);
      logic [15:0] r;
      spi_begin();
      spi_bits(16'h0005, 8, r);
      spi_bits(16'h0000, 8, r);
      s0 = r[7:0];
      s1 = s0;
      if (nb > 1) begin
         spi_bits(16'h0000, 8, r);
         s1 = r[7:0];
      end
      spi_end();
   endtask

   function automatic logic [7:0] unused8(input logic [7:0] x);
      return x;
   endfunction

   task automatic st_is(input string tag, input logic [7:0] exp);
      logic [7:0] a, b;
      read_status(1, a, b);
      chk(tag, a, exp);
   endtask

   task automatic t_powerup();
      // cs held low through reset: WREN must not count
      logic [15:0] r;
      tick(5);
      rst_n = 1'b1;
      tick(10);
      spi_bits(16'h0006, 8, r);
      spi_end();
      st_is("R10 no cmd without cs fall", 8'h00);
      chk("R10 prot after reset", {6'd0, prot_area}, 8'h00);
      chk("R11 oe idle", {7'd0, miso_oe}, 8'h00);
   endtask

   task automatic t_wel();
      logic [15:0] r;
      cmd(16'h0006, 8);
      st_is("R2 WREN sets flag", 8'h02);
      cmd(16'h0004, 8);
      st_is("R2 WRDI clears flag", 8'h00);
      cmd(16'h000C, 9);
      st_is("R2 nine-bit WREN ignored", 8'h00);
      spi_begin();
      spi_bits(16'h0006, 8, r);
      chk("R11 oe low in non-read cmd", {7'd0, miso_oe}, 8'h00);
      spi_end();
      chk("R11 oe low after read", {7'd0, miso_oe}, 8'h00);
   endtask

   task automatic t_unknown();
      cmd(16'h00AA, 8);
      st_is("R9 unknown opcode ignored", 8'h02);
   endtask

   task automatic t_write_ok();
      logic [7:0] a, b;
      cmd(16'h010C, 16);
      read_status(2, a, b);
      chk("R7 busy and wel during cycle", a, 8'h03);
      chk("R1 repeated status byte", b, 8'h03);
      chk("R8 prot not yet applied", {6'd0, prot_area}, 8'h00);
      tick(TW + 100);
      st_is("R7 R8 status after cycle", 8'h0C);
      chk("R8 prot_area after cycle", {6'd0, prot_area}, 8'h03);
   endtask

   task automatic t_no_wel();
      cmd(16'h0100, 16);
      tick(TW + 100);
      st_is("R3 write without wel ignored", 8'h0C);
   endtask

   task automatic t_wp();
      logic [15:0] r;
      cmd(16'h0006, 8);
      spi_begin();
      spi_bits(16'h0001, 8, r);
      wp_n = 1'b0;
      tick(3);
      wp_n = 1'b1;
      spi_bits(16'h0000, 8, r);
      spi_end();
      tick(TW + 100);
      st_is("R5 wp pulse rejects write", 8'h0E);
   endtask

   task automatic t_len();
      logic [15:0] r;
      spi_begin();
      spi_bits(16'h0100, 16, r);
      spi_bits(16'h0000, 1, r);
      spi_end();
      tick(TW + 100);
      st_is("R4 17-bit write ignored", 8'h0E);
      cmd(16'h0100, 15);
      tick(TW + 100);
      st_is("R4 15-bit write ignored", 8'h0E);
   endtask

   task automatic t_busy();
      cmd(16'h0104, 16);
      cmd(16'h0108, 16);
      cmd(16'h0004, 8);
      st_is("R6 wrdi ignored while busy", 8'h0F);
      tick(TW + 100);
      st_is("R6 second write ignored", 8'h04);
      chk("R8 prot_area upper quarter", {6'd0, prot_area}, 8'h01);
   endtask

   task automatic t_mask();
      cmd(16'h0006, 8);
      cmd(16'h01F3, 16);
      tick(TW + 100);
      st_is("R8 R1 only bits 3:2 used", 8'h00);
   endtask

   task automatic t_mode3();
      logic [7:0] a, b;
      mode3 = 1'b1;
      cmd(16'h0006, 8);
      cmd(16'h0108, 16);
      tick(TW + 100);
      read_status(2, a, b);
      chk("R1 mode3 read byte0", a, 8'h08);
      chk("R1 mode3 read byte1", b, 8'h08);
      mode3 = 1'b0;
      sck = 1'b0;
      tick(HP);
   endtask

   initial begin
      t_powerup();
      t_wel();
      cmd(16'h0006, 8);
      t_unknown();
      t_write_ok();
      t_no_wel();
      t_wp();
      t_len();
      cmd(16'h0004, 8);
      cmd(16'h0006, 8);
      t_busy();
      t_mask();
      t_mode3();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%h exp=%h", unused8(8'h00), 8'h01);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule